// File: doc/BRIEF.md
# TLV Configuration Stream Decoder

This block takes a stream of 16-bit configuration words from a host link and turns it into a set of acquisition settings. A stream starts with a 32-bit start marker and holds any number of type-length-value records. It closes with a 32-bit end marker. Every 32-bit quantity on the link is sent as two words, low word first.

Each record begins with a header word. The upper byte of the header is a register index and the lower byte is the payload length in words. The payload words go into a shadow copy of the settings: a mode word, a clock divider, a sample count, a trigger position, a global trigger word, a channel enable mask, and a table of per-stage trigger words and counts. The live outputs change only when a correct end marker arrives. All of them change in the same cycle, and a one-cycle `config_done` pulse marks the update. A malformed header or a bad end marker sets a sticky error flag and sends the decoder back to hunting for a start marker.

The block is used between the host link and the capture logic. Because of the shadow copy, the capture logic never sees a half-applied configuration.

Top module: `cfg_tlv_decoder`

## Requirements
- R1: During and after a synchronous reset, every live setting output, `config_done` and `cfg_error` are zero, and the decoder is hunting for a start marker.
- R2: While the decoder hunts, it ignores every word until it sees 0xF5A5 followed directly by 0xF5A5. Records or end markers received before that leave the outputs unchanged, raise no `config_done` pulse and set no error.
- R3: After the start marker, each header word carries the index in bits 15:8 and the length in bits 7:0. The valid pairs (index:length) are 0:1 mode, 1:2 divider, 3:2 sample count, 5:2 trigger position, 7:1 global trigger, 8:1 channel enable, and 64:10*STAGES trigger table (160 with 16 stages).
- R4: Each 2-word payload (divider, sample count, trigger position) and each stage count is assembled with the first word as bits 15:0 and the second word as bits 31:16.
- R5: The 1-word payloads load the mode, global trigger and channel enable outputs. The mode outputs decode mode bit 0 as trigger enable, bit 3 as run-length, bit 5 as half-channel, bit 6 as quarter-channel, bit 8 as filter and bit 12 as streaming.
- R6: The trigger table payload carries, in order, STAGES words of each field in the sequence mask0, mask1, value0, value1, edge0, edge1, logic0, logic1 (stage 0 first), then one 2-word count per stage. Field f of stage s appears on `trig_words[(f*STAGES+s)*16 +: 16]`, and the count of stage s appears on `trig_counts[s*32 +: 32]`.
- R7: The live outputs change only in the cycle after the end marker's second 0xFA5A word is accepted. In that same cycle `config_done` is high, and it is high for that one cycle only.
- R8: A header whose index is unknown or whose length differs from the fixed length for its index sets `cfg_error`. The decoder then returns to hunting, and nothing from that stream reaches the outputs.
- R9: A header-position word of 0xFA5A must be followed by 0xFA5A. Any other word sets `cfg_error`, returns the decoder to hunting and commits nothing.
- R10: A setting with no record in a committed stream keeps its previous live value.
- R11: `cfg_error` stays high until reset, and later streams still commit normally while it is set.
- R12: `in_ready` is always high, so a word is taken on every cycle with `in_valid` high. Idle cycles between words do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Configuration word valid |
| in_data | input | 16 | Configuration word |
| in_ready | output | 1 | Word accepted when valid (always high) |
| mode_word | output | 16 | Live mode word |
| trig_en | output | 1 | Mode bit 0 |
| rle_en | output | 1 | Mode bit 3 |
| half_ch | output | 1 | Mode bit 5 |
| quarter_ch | output | 1 | Mode bit 6 |
| filter_en | output | 1 | Mode bit 8 |
| stream_en | output | 1 | Mode bit 12 |
| clk_div | output | 32 | Live clock divider |
| sample_cnt | output | 32 | Live sample count |
| trig_pos | output | 32 | Live trigger position |
| trig_global | output | 16 | Live global trigger word |
| ch_enable | output | 16 | Live channel enable mask |
| trig_words | output | 8*STAGES*16 | Per-stage trigger fields, field-major |
| trig_counts | output | STAGES*32 | Per-stage trigger counts |
| config_done | output | 1 | One-cycle pulse when live settings update |
| cfg_error | output | 1 | Sticky framing or header error |

## Verification
The assertions check three properties on every cycle:
- the live mode and divider hold still except on a `config_done` cycle;
- the done pulse lasts one cycle;
- the error flag never falls, and it rises only when the decoder was outside the hunt.

The scenarios alone can show the bit placement: which payload word lands in which output half or table slot, that a skipped record keeps its earlier value, and that framing mistakes leave the outputs untouched. The bench sends a series of streams, each with a different subset and order of records. Their values are computed arithmetically and compared against a model kept in the bench.

// File: rtl/cfg_tlv_decoder.sv
module cfg_tlv_decoder #(
  parameter int STAGES = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [15:0]              in_data,
  output logic                     in_ready,
  output logic [15:0]              mode_word,
  output logic                     trig_en,
  output logic                     rle_en,
  output logic                     half_ch,
  output logic                     quarter_ch,
  output logic                     filter_en,
  output logic                     stream_en,
  output logic [31:0]              clk_div,
  output logic [31:0]              sample_cnt,
  output logic [31:0]              trig_pos,
  output logic [15:0]              trig_global,
  output logic [15:0]              ch_enable,
  output logic [8*STAGES*16-1:0]   trig_words,
  output logic [STAGES*32-1:0]     trig_counts,
  output logic                     config_done,
  output logic                     cfg_error
);

  localparam int TBL_LEN = STAGES * 10;
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [15:0] START_W = 16'hF5A5;
  localparam logic [15:0] END_W   = 16'hFA5A;

  typedef enum logic [2:0] {WAIT_LO, WAIT_HI, HDR, PAY, END_HI} st_t;
  st_t st;

  logic [15:0] sh_mode, sh_glb, sh_chen, lv_mode, lv_glb, lv_chen;
  logic [31:0] sh_div, sh_cnt, sh_pos, lv_div, lv_cnt, lv_pos;
  logic [15:0] sh_tbl [0:7][0:STAGES-1];
  logic [15:0] lv_tbl [0:7][0:STAGES-1];
  logic [31:0] sh_tc  [0:STAGES-1];
  logic [31:0] lv_tc  [0:STAGES-1];

  logic [7:0]    cur_idx, rem;
  logic          half;
  logic [3:0]    fld;
  logic [SW-1:0] stg;
  logic [7:0]    exp_len;
  logic          acc, hdr_ok;

  assign in_ready = 1'b1;
  assign acc      = in_valid & in_ready;

  always_comb begin
    case (in_data[15:8])
      8'd0, 8'd7, 8'd8: exp_len = 8'd1;
      8'd1, 8'd3, 8'd5: exp_len = 8'd2;
      8'd64:            exp_len = 8'(TBL_LEN);
      default:          exp_len = 8'd0;
    endcase
  end
  assign hdr_ok = (exp_len != 8'd0) && (in_data[7:0] == exp_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= WAIT_LO;
      cfg_error <= 1'b0;
      config_done <= 1'b0;
      cur_idx <= '0; rem <= '0; half <= 1'b0; fld <= '0; stg <= '0;
      sh_mode <= '0; sh_glb <= '0; sh_chen <= '0;
      sh_div <= '0; sh_cnt <= '0; sh_pos <= '0;
      lv_mode <= '0; lv_glb <= '0; lv_chen <= '0;
      lv_div <= '0; lv_cnt <= '0; lv_pos <= '0;
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < STAGES; s++) begin
          sh_tbl[f][s] <= '0;
          lv_tbl[f][s] <= '0;
        end
      for (int s = 0; s < STAGES; s++) begin
        sh_tc[s] <= '0;
        lv_tc[s] <= '0;
      end
    end else begin
      config_done <= 1'b0;
      if (acc) begin
        case (st)
          WAIT_LO: if (in_data == START_W) st <= WAIT_HI;
          WAIT_HI: begin
            if (in_data == START_W) begin
              st <= HDR;
              sh_mode <= lv_mode; sh_glb <= lv_glb; sh_chen <= lv_chen;
              sh_div <= lv_div; sh_cnt <= lv_cnt; sh_pos <= lv_pos;
              sh_tbl <= lv_tbl;
              sh_tc  <= lv_tc;
            end else begin
              st <= WAIT_LO;
            end
          end
          HDR: begin
            if (in_data == END_W) begin
              st <= END_HI;
            end else if (hdr_ok) begin
              st <= PAY;
              cur_idx <= in_data[15:8];
              rem <= in_data[7:0] - 8'd1;
              half <= 1'b0;
              fld <= '0;
              stg <= '0;
            end else begin
              cfg_error <= 1'b1;
              st <= WAIT_LO;
            end
          end
          PAY: begin
            half <= ~half;
            case (cur_idx)
              8'd0: sh_mode <= in_data;
              8'd1: if (half) sh_div[31:16] <= in_data; else sh_div[15:0] <= in_data;
              8'd3: if (half) sh_cnt[31:16] <= in_data; else sh_cnt[15:0] <= in_data;
              8'd5: if (half) sh_pos[31:16] <= in_data; else sh_pos[15:0] <= in_data;
              8'd7: sh_glb <= in_data;
              8'd8: sh_chen <= in_data;
              default: begin
                if (fld < 4'd8) begin
                  sh_tbl[fld[2:0]][stg] <= in_data;
                  if (stg == SW'(STAGES - 1)) begin
                    stg <= '0;
                    fld <= fld + 4'd1;
                  end else begin
                    stg <= stg + SW'(1);
                  end
                end else begin
                  if (half) begin
                    sh_tc[stg][31:16] <= in_data;
                    if (stg != SW'(STAGES - 1)) stg <= stg + SW'(1);
                  end else begin
                    sh_tc[stg][15:0] <= in_data;
                  end
                end
              end
            endcase
            if (rem == 8'd0) st <= HDR;
            else rem <= rem - 8'd1;
          end
          END_HI: begin
            st <= WAIT_LO;
            if (in_data == END_W) begin
              config_done <= 1'b1;
              lv_mode <= sh_mode; lv_glb <= sh_glb; lv_chen <= sh_chen;
              lv_div <= sh_div; lv_cnt <= sh_cnt; lv_pos <= sh_pos;
              lv_tbl <= sh_tbl;
              lv_tc  <= sh_tc;
            end else begin
              cfg_error <= 1'b1;
            end
          end
          default: st <= WAIT_LO;
        endcase
      end
    end
  end

  assign mode_word   = lv_mode;
  assign trig_en     = lv_mode[0];
  assign rle_en      = lv_mode[3];
  assign half_ch     = lv_mode[5];
  assign quarter_ch  = lv_mode[6];
  assign filter_en   = lv_mode[8];
  assign stream_en   = lv_mode[12];
  assign clk_div     = lv_div;
  assign sample_cnt  = lv_cnt;
  assign trig_pos    = lv_pos;
  assign trig_global = lv_glb;
  assign ch_enable   = lv_chen;

  for (genvar f = 0; f < 8; f++) begin : g_fld
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      assign trig_words[(f*STAGES+s)*16 +: 16] = lv_tbl[f][s];
    end
  end
  for (genvar s = 0; s < STAGES; s++) begin : g_cnt
    assign trig_counts[s*32 +: 32] = lv_tc[s];
  end

  assert_live_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !config_done |-> ($stable(mode_word) && $stable(clk_div)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    config_done |=> !config_done);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_error |=> cfg_error);
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_error) |-> ($past(st) == HDR || $past(st) == END_HI));
  assert_done_rehunt_R9: assert property (@(posedge clk) disable iff (rst)
    config_done |-> st == WAIT_LO);

endmodule

// File: tb/cfg_tlv_decoder_tb.sv
`timescale 1ns/1ps
module cfg_tlv_decoder_tb_top;
  localparam int S = 16;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, trig_en, rle_en, half_ch, quarter_ch, filter_en, stream_en;
  logic config_done, cfg_error;
  logic [15:0] mode_word, trig_global, ch_enable;
  logic [31:0] clk_div, sample_cnt, trig_pos;
  logic [8*S*16-1:0] trig_words;
  logic [S*32-1:0] trig_counts;

  int vec = 0, bad = 0;
  bit finished = 0;

  logic [15:0] e_mode, e_glb, e_chen;
  logic [31:0] e_div, e_cnt, e_pos;
  logic [15:0] e_tbl [0:8*S-1];
  logic [31:0] e_tc  [0:S-1];

  cfg_tlv_decoder #(.STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mode_word(mode_word), .trig_en(trig_en), .rle_en(rle_en), .half_ch(half_ch),
    .quarter_ch(quarter_ch), .filter_en(filter_en), .stream_en(stream_en),
    .clk_div(clk_div), .sample_cnt(sample_cnt), .trig_pos(trig_pos),
    .trig_global(trig_global), .ch_enable(ch_enable), .trig_words(trig_words),
    .trig_counts(trig_counts), .config_done(config_done), .cfg_error(cfg_error));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input bit gap);
    if (gap) begin
      @(negedge clk); in_valid = 1'b0;
    end
    @(negedge clk); in_valid = 1'b1; in_data = w;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0; in_data = 16'h0;
  endtask

  task automatic send32(input logic [31:0] v, input bit gap);
    send(v[15:0], gap);
    send(v[31:16], gap);
  endtask

  task automatic check_live(input string req);
    chk(mode_word == e_mode, req, mode_word, e_mode);
    chk({trig_en, rle_en, half_ch, quarter_ch, filter_en, stream_en} ==
        {e_mode[0], e_mode[3], e_mode[5], e_mode[6], e_mode[8], e_mode[12]},
        "R5 mode bits", {trig_en, rle_en, half_ch, quarter_ch, filter_en, stream_en},
        {e_mode[0], e_mode[3], e_mode[5], e_mode[6], e_mode[8], e_mode[12]});
    chk(clk_div == e_div, "R4 divider", clk_div, e_div);
    chk(sample_cnt == e_cnt, "R4 sample count", sample_cnt, e_cnt);
    chk(trig_pos == e_pos, "R4 trigger position", trig_pos, e_pos);
    chk(trig_global == e_glb, "R5 global trigger", trig_global, e_glb);
    chk(ch_enable == e_chen, "R5 channel enable", ch_enable, e_chen);
    for (int i = 0; i < 8*S; i++)
      chk(trig_words[i*16 +: 16] == e_tbl[i], "R6 table word", trig_words[i*16 +: 16], e_tbl[i]);
    for (int s = 0; s < S; s++)
      chk(trig_counts[s*32 +: 32] == e_tc[s], "R6 stage count", trig_counts[s*32 +: 32], e_tc[s]);
  endtask

  task automatic send_rec(input int r, input int n, input bit gap);
    case (r)
      0: begin e_mode = 16'(n * 16'h1111) ^ 16'h0129; send(16'h0001, gap); send(e_mode, gap); end
      1: begin e_div = 32'(n * 32'h01010203) ^ 32'hC0DE0001; send(16'h0102, gap); send32(e_div, gap); end
      2: begin e_cnt = 32'(n * 32'h00370041) + 32'h12340000; send(16'h0302, gap); send32(e_cnt, gap); end
      3: begin e_pos = 32'(n * 32'h11000011) ^ 32'h00FF00FF; send(16'h0502, gap); send32(e_pos, gap); end
      4: begin e_glb = 16'(n * 16'h0707) ^ 16'h8001; send(16'h0701, gap); send(e_glb, gap); end
      5: begin e_chen = 16'(n * 16'h3003) ^ 16'h00F0; send(16'h0801, gap); send(e_chen, gap); end
      default: begin
        send({8'd64, 8'(S*10)}, gap);
        for (int i = 0; i < 8*S; i++) begin
          e_tbl[i] = 16'(n * 16'h1357 + i * 16'h0101) ^ 16'hA5A5;
          send(e_tbl[i], 1'b0);
        end
        for (int s = 0; s < S; s++) begin
          e_tc[s] = 32'(n * 32'h00100001 + s * 32'h01000007);
          send32(e_tc[s], 1'b0);
        end
      end
    endcase
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; vec++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    e_mode = '0; e_glb = '0; e_chen = '0; e_div = '0; e_cnt = '0; e_pos = '0;
    for (int i = 0; i < 8*S; i++) e_tbl[i] = '0;
    for (int s = 0; s < S; s++) e_tc[s] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(config_done == 1'b0 && cfg_error == 1'b0, "R1 flags in reset", {config_done, cfg_error}, 0);
    rst = 1'b0;
    @(negedge clk);
    check_live("R1 reset mode");
    chk(in_ready == 1'b1, "R12 ready", in_ready, 1);

    // R2: records and end marker before any start are ignored
    send(16'hF5A5, 1'b0); send(16'h1234, 1'b0);
    send(16'h0001, 1'b0); send(16'hBEEF, 1'b0);
    send(16'hFA5A, 1'b0); send(16'hFA5A, 1'b0);
    idle();
    chk(config_done == 1'b0, "R2 no commit while hunting", config_done, 0);
    chk(cfg_error == 1'b0, "R2 no error while hunting", cfg_error, 0);
    check_live("R2 outputs untouched");

    // sweep of streams with varying record subsets and order (R3 R4 R5 R6 R10 R12)
    for (int n = 0; n < 12; n++) begin
      int msk;
      bit gap;
      msk = (n == 0) ? 7'h7F : ((n * 37 + 11) & 7'h7F);
      gap = n[0];
      send32(32'hF5A5F5A5, gap);
      for (int k = 0; k < 7; k++) begin
        int r;
        r = n[1] ? 6 - k : k;
        if (msk[r]) send_rec(r, n + 1, gap);
      end
      send(16'hFA5A, gap);
      @(negedge clk);
      chk(config_done == 1'b0, "R7 no done before last end word", config_done, 0);
      in_valid = 1'b1; in_data = 16'hFA5A;
      @(posedge clk);
      idle();
      chk(config_done == 1'b1, "R7 done pulse", config_done, 1);
      check_live("R3 R10 committed mode");
      @(negedge clk);
      chk(config_done == 1'b0, "R7 done one cycle", config_done, 0);
    end
    chk(cfg_error == 1'b0, "R8 no error after clean streams", cfg_error, 0);

    // R8: wrong length for a known index
    send32(32'hF5A5F5A5, 1'b0);
    send(16'h0001, 1'b0); send(16'h7777, 1'b0);
    send(16'h0002, 1'b0);
    idle();
    chk(cfg_error == 1'b1, "R8 length mismatch error", cfg_error, 1);
    send(16'h4444, 1'b0); send(16'hFA5A, 1'b0); send(16'hFA5A, 1'b0);
    idle();
    chk(config_done == 1'b0, "R8 nothing committed", config_done, 0);
    check_live("R8 outputs kept");

    // R8: unknown index, then a clean stream commits while the error stays (R11)
    send32(32'hF5A5F5A5, 1'b0);
    send(16'h0201, 1'b0);
    idle();
    chk(cfg_error == 1'b1, "R11 error sticky", cfg_error, 1);
    send32(32'hF5A5F5A5, 1'b0);
    send_rec(4, 99, 1'b0);
    send32(32'hFA5AFA5A, 1'b0);
    idle();
    chk(config_done == 1'b1, "R11 commit with error set", config_done, 1);
    check_live("R11 commit values");

    // R9: bad end marker second word
    send32(32'hF5A5F5A5, 1'b0);
    send(16'h0801, 1'b0); send(16'h5A5A, 1'b0);
    send(16'hFA5A, 1'b0); send(16'h1234, 1'b0);
    idle();
    chk(config_done == 1'b0, "R9 no commit on bad end", config_done, 0);
    check_live("R9 outputs kept");
    chk(cfg_error == 1'b1, "R9 error", cfg_error, 1);

    // R1: reset clears everything again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    e_mode = '0; e_glb = '0; e_chen = '0; e_div = '0; e_cnt = '0; e_pos = '0;
    for (int i = 0; i < 8*S; i++) e_tbl[i] = '0;
    for (int s = 0; s < S; s++) e_tc[s] = '0;
    chk(cfg_error == 1'b0, "R1 error cleared by reset", cfg_error, 0);
    check_live("R1 live cleared");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule